// File: doc/BRIEF.md
# I2C Fan Controller Register Bank

This block sits on a two-wire I2C bus as a target device and runs three cooling fans. A bus controller addresses it at the 7-bit address 0x74, sends a one-byte register pointer, and then either writes data bytes or issues a repeated start and reads bytes back. The write side of the register bank holds a per-fan enable mask and three PWM duty values given in percent. The read side returns the enable mask and three fan speeds in revolutions per second, which are measured from tachometer inputs.

Register pointer 0 is the control register. Pointers 1, 2 and 3 belong to fans 1, 2 and 3. A write to 1..3 sets a duty cycle. A read from 1..3 returns the measured speed, so the same pointer means different data in the two directions. Both SCL and SDA are oversampled by the system clock. SDA is driven only as an active-low output enable, and no clock stretching is ever applied.

Top module: `fan_i2c_ctrl`

## Requirements
- R1: Only the address byte 0xE8/0xE9 (device address 0x74 followed by the R/W bit) is ACKed. Any other address gets no ACK, and every byte that follows it up to the next START or STOP leaves all registers unchanged.
- R2: After a write-direction address, the register pointer byte is ACKed when its value is 0..3 and NACKed when it is above 3.
- R3: After reset, all three enable bits are 1 and every duty is 30 percent.
- R4: Bits 2:0 of register 0 enable fans 1..3 (bit 0 = fan 1). A read of register 0 returns the mask in bits 2:0 with bits 7:3 zero.
- R5: A write to register 1, 2 or 3 sets the duty of fan 1, 2 or 3. A written value above 100 is stored as 100.
- R6: Each PWM output repeats every 100 steps of PWM_DIV clock cycles and stays high for duty steps of each period. A fan whose enable bit is 0 holds its output low.
- R7: A read of register 1..3 returns the latched speed of that fan, not its duty. A read with the pointer above 3 returns 0x00.
- R8: Each tachometer input is synchronised and its rising edges are counted. Every SEC_TICKS clock cycles after reset the count is copied into the speed register, saturating at 255, and the counter restarts. An edge that lands in the copy cycle is counted in exactly one window.
- R9: The pointer advances by one after every data byte, for both writes and reads. A write data byte arriving while the pointer is above 3 is NACKed and discarded.
- R10: A read-direction address, whether it follows a repeated START or a fresh START, returns data starting at the current pointer.
- R11: An SDA edge while SCL is high is a START (falling) or a STOP (rising). A STOP returns the target to idle, and in idle SDA is released (sda_oe_o = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| tach_i | input | 3 | Tachometer pulse inputs, bit 0 = fan 1 |
| pwm_o | output | 3 | PWM fan drive outputs, bit 0 = fan 1 |

## Verification
A tachometer rising edge and the once-per-window copy of the count into the speed register can fall in the same clock cycle. If that coincidence is mishandled, one pulse is either lost or counted twice. The bench places a single pulse on fan 1 at a sweep of offsets, from several cycles before a window boundary to several cycles after it, with a known number of pulses inside each window. It then reads every window's speed over the bus. Each window must report its own pulses plus at most the two boundary pulses next to it, and the sum over all windows must equal the number of pulses driven.

// File: rtl/fan_pkg.sv
package fan_pkg;
    localparam int unsigned NUM_FANS  = 3;
    localparam int unsigned PWM_STEPS = 100;
    localparam logic [6:0]  DUTY_MAX  = 7'd100;
    localparam logic [6:0]  DUTY_RST  = 7'd30;
    localparam logic [7:0]  REG_LAST  = 8'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_RACK
    } i2c_st_t;
endpackage

// File: rtl/fan_i2c_target.sv
module fan_i2c_target
    import fan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h74
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i
);
    typedef struct packed {
        logic [1:0] scl_sync;
        logic [1:0] sda_sync;
        logic       scl_prev;
        logic       sda_prev;
        i2c_st_t    st;
        i2c_st_t    after;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [7:0] ptr;
        logic       sda_oe;
        logic       mack;
    } tgt_t;

    tgt_t q, n;
    logic scl, sda, rise, fall, start_ev, stop_ev, load_rd;

    assign scl      = q.scl_sync[1];
    assign sda      = q.sda_sync[1];
    assign rise     = scl & ~q.scl_prev;
    assign fall     = ~scl & q.scl_prev;
    assign start_ev = scl & q.scl_prev & q.sda_prev & ~sda;
    assign stop_ev  = scl & q.scl_prev & ~q.sda_prev & sda;

    function automatic logic [7:0] ptr_inc(input logic [7:0] p);
        return (p == 8'hFF) ? p : p + 8'd1;
    endfunction

    always_comb begin
        n          = q;
        load_rd    = 1'b0;
        wr_en_o    = 1'b0;
        n.scl_sync = {q.scl_sync[0], scl_i};
        n.sda_sync = {q.sda_sync[0], sda_i};
        n.scl_prev = scl;
        n.sda_prev = sda;
        if (start_ev) begin
            n.st     = ST_ADDR;
            n.bitcnt = 4'd0;
            n.sda_oe = 1'b0;
        end else if (stop_ev) begin
            n.st     = ST_IDLE;
            n.sda_oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_REG, ST_WR: begin
                    if (rise && q.bitcnt < 4'd8) begin
                        n.shreg  = {q.shreg[6:0], sda};
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (fall && q.bitcnt == 4'd8) begin
                        n.bitcnt = 4'd0;
                        n.st     = ST_ACK;
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                n.sda_oe = 1'b1;
                                n.after  = q.shreg[0] ? ST_RD : ST_REG;
                            end else begin
                                n.st = ST_IDLE;
                            end
                        end else if (q.st == ST_REG) begin
                            if (q.shreg <= REG_LAST) begin
                                n.sda_oe = 1'b1;
                                n.ptr    = q.shreg;
                                n.after  = ST_WR;
                            end else begin
                                n.st = ST_IDLE;
                            end
                        end else begin
                            if (q.ptr <= REG_LAST) begin
                                n.sda_oe = 1'b1;
                                wr_en_o  = 1'b1;
                                n.after  = ST_WR;
                            end else begin
                                n.st = ST_IDLE;
                            end
                            n.ptr = ptr_inc(q.ptr);
                        end
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        n.sda_oe = 1'b0;
                        n.bitcnt = 4'd0;
                        if (q.after == ST_RD) load_rd = 1'b1;
                        else                  n.st    = q.after;
                    end
                end
                ST_RD: begin
                    if (fall) begin
                        if (q.bitcnt == 4'd8) begin
                            n.sda_oe = 1'b0;
                            n.mack   = 1'b0;
                            n.st     = ST_RACK;
                        end else begin
                            n.shreg  = {q.shreg[6:0], 1'b0};
                            n.sda_oe = ~q.shreg[6];
                            n.bitcnt = q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (rise) n.mack = ~sda;
                    if (fall) begin
                        if (q.mack) load_rd = 1'b1;
                        else        n.st    = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
        if (load_rd) begin
            n.shreg  = rd_data_i;
            n.sda_oe = ~rd_data_i[7];
            n.ptr    = ptr_inc(q.ptr);
            n.bitcnt = 4'd1;
            n.st     = ST_RD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.scl_sync <= 2'b11;
            q.sda_sync <= 2'b11;
            q.scl_prev <= 1'b1;
            q.sda_prev <= 1'b1;
            q.st       <= ST_IDLE;
            q.after    <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o  = q.sda_oe;
    assign wr_addr_o = q.ptr;
    assign wr_data_o = q.shreg;
    assign rd_addr_o = q.ptr;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_oe_o); // R11
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.st == ST_IDLE)); // R11
    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o <= REG_LAST)); // R9
endmodule

// File: rtl/fan_regs.sv
module fan_regs
    import fan_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [7:0]                   wr_addr_i,
    input  logic [7:0]                   wr_data_i,
    input  logic [7:0]                   rd_addr_i,
    output logic [7:0]                   rd_data_o,
    input  logic [NUM_FANS-1:0][7:0]     rps_i,
    output logic [NUM_FANS-1:0]          en_o,
    output logic [NUM_FANS-1:0][6:0]     duty_o
);
    typedef struct packed {
        logic [NUM_FANS-1:0]      en;
        logic [NUM_FANS-1:0][6:0] duty;
    } regs_t;

    regs_t q, n;

    always_comb begin
        n = q;
        if (wr_en_i) begin
            if (wr_addr_i == 8'd0) n.en = wr_data_i[NUM_FANS-1:0];
            for (int i = 0; i < NUM_FANS; i++) begin
                if (wr_addr_i == 8'(i + 1))
                    n.duty[i] = (wr_data_i > 8'(DUTY_MAX)) ? DUTY_MAX : wr_data_i[6:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.en <= '1;
            for (int i = 0; i < NUM_FANS; i++) q.duty[i] <= DUTY_RST;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr_i == 8'd0) rd_data_o = {{(8 - NUM_FANS){1'b0}}, q.en};
        for (int i = 0; i < NUM_FANS; i++) begin
            if (rd_addr_i == 8'(i + 1)) rd_data_o = rps_i[i];
        end
    end

    assign en_o   = q.en;
    assign duty_o = q.duty;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 8'd0) |=> (en_o == $past(wr_data_i[NUM_FANS-1:0]))); // R4

    for (genvar g = 0; g < NUM_FANS; g++) begin : g_chk
        AST_DUTY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            duty_o[g] <= DUTY_MAX); // R5
    end
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm
    import fan_pkg::*;
#(
    parameter int unsigned PWM_DIV = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [6:0] duty_i,
    output logic       pwm_o
);
    localparam int unsigned DIV_W = (PWM_DIV > 1) ? $clog2(PWM_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [6:0]       step;
        logic             out;
    } pwm_t;

    pwm_t q, n;

    always_comb begin
        n = q;
        if (q.div == DIV_W'(PWM_DIV - 1)) begin
            n.div  = '0;
            n.step = (q.step == 7'(PWM_STEPS - 1)) ? 7'd0 : q.step + 7'd1;
        end else begin
            n.div = q.div + DIV_W'(1);
        end
        n.out = en_i && (q.step < duty_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign pwm_o = q.out;

    AST_PWM_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o); // R6
    AST_PWM_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && duty_i >= DUTY_MAX) |=> pwm_o); // R6
endmodule

// File: rtl/fan_tach.sv
module fan_tach (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tach_i,
    input  logic       tick_i,
    output logic [7:0] rps_o
);
    typedef struct packed {
        logic [2:0] sync;
        logic [7:0] cnt;
        logic [7:0] rps;
    } tach_t;

    tach_t q, n;
    logic       pulse;
    logic [8:0] total;

    assign pulse = q.sync[1] & ~q.sync[2];
    assign total = {1'b0, q.cnt} + {8'd0, pulse};

    always_comb begin
        n      = q;
        n.sync = {q.sync[1:0], tach_i};
        if (tick_i) begin
            n.rps = total[8] ? 8'hFF : total[7:0];
            n.cnt = 8'd0;
        end else if (pulse && q.cnt != 8'hFF) begin
            n.cnt = q.cnt + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rps_o = q.rps;

    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(rps_o)); // R8
    AST_SPEED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !pulse && q.cnt == 8'd0) |=> (rps_o == 8'd0)); // R8
endmodule

// File: rtl/fan_i2c_ctrl.sv
module fan_i2c_ctrl
    import fan_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR  = 7'h74,
    parameter int unsigned PWM_DIV   = 100,
    parameter int unsigned SEC_TICKS = 250_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [NUM_FANS-1:0] tach_i,
    output logic [NUM_FANS-1:0] pwm_o
);
    localparam int unsigned SEC_W = (SEC_TICKS > 1) ? $clog2(SEC_TICKS) : 1;

    logic                     wr_en;
    logic [7:0]               wr_addr, wr_data, rd_addr, rd_data;
    logic [NUM_FANS-1:0]      en;
    logic [NUM_FANS-1:0][6:0] duty;
    logic [NUM_FANS-1:0][7:0] rps;
    logic [SEC_W-1:0]         sec_d, sec_q;
    logic                     sec_tick;

    assign sec_tick = (sec_q == SEC_W'(SEC_TICKS - 1));

    always_comb begin
        sec_d = sec_tick ? '0 : sec_q + SEC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= sec_d;
    end

    fan_i2c_target #(.DEV_ADDR(DEV_ADDR)) u_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    fan_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .rps_i     (rps),
        .en_o      (en),
        .duty_o    (duty)
    );

    for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
        fan_pwm #(.PWM_DIV(PWM_DIV)) u_pwm (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en[g]),
            .duty_i (duty[g]),
            .pwm_o  (pwm_o[g])
        );
        fan_tach u_tach (
            .clk    (clk),
            .rst_n  (rst_n),
            .tach_i (tach_i[g]),
            .tick_i (sec_tick),
            .rps_o  (rps[g])
        );
    end
endmodule

// File: tb/tb_fan_i2c_ctrl.sv
module tb_fan_i2c_ctrl;
    localparam int T = 4000;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] tach = 3'b000;
    logic       sda_oe;
    logic       sda_line;
    logic [2:0] pwm;
    int         cyc = 0;
    int         nchk = 0;
    int         nfail = 0;
    bit         done = 0;

    logic [7:0] wbuf [4];
    logic [7:0] rbuf [6];
    logic       aack, rack;
    logic       dack [4];
    int         pcnt [3];
    logic [2:0] m_en;
    int         m_duty [3];

    assign sda_line = !(m_low || sda_oe);

    always #2 clk = ~clk;

    fan_i2c_ctrl #(.DEV_ADDR(7'h74), .PWM_DIV(1), .SEC_TICKS(T)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .tach_i   (tach),
        .pwm_o    (pwm)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        nchk++;
        if (act < lo || act > hi) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic hclk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; scl = 1'b1; hclk(H);
        m_low = 1'b1; hclk(H);
        scl = 1'b0; hclk(3);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; hclk(H);
        scl = 1'b1; hclk(H);
        m_low = 1'b1; hclk(H);
        scl = 1'b0; hclk(3);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hclk(H);
        scl = 1'b1; hclk(H);
        m_low = 1'b0; hclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; hclk(H);
            scl = 1'b1; hclk(H);
            scl = 1'b0; hclk(3);
        end
        m_low = 1'b0; hclk(H);
        scl = 1'b1; hclk(H / 2);
        ack = ~sda_line; hclk(H / 2);
        scl = 1'b0; hclk(3);
    endtask

    task automatic recv_byte(input logic ackit, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            hclk(H);
            scl = 1'b1; hclk(H / 2);
            b[i] = sda_line; hclk(H / 2);
            scl = 1'b0; hclk(3);
        end
        m_low = ackit; hclk(H);
        scl = 1'b1; hclk(H);
        scl = 1'b0; hclk(3);
        m_low = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] r, input int n);
        logic a;
        bus_start();
        send_byte(8'hE8, aack);
        send_byte(r, rack);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            dack[i] = a;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] r, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hE8, aack);
        send_byte(r, rack);
        bus_rstart();
        send_byte(8'hE9, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
    endtask

    task automatic measure_pwm();
        for (int f = 0; f < 3; f++) pcnt[f] = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            for (int f = 0; f < 3; f++) pcnt[f] += int'(pwm[f]);
        end
    endtask

    function automatic int exp_pwm(input int f);
        return m_en[f] ? m_duty[f] : 0;
    endfunction

    function automatic int clamp(input int d);
        return (d > 100) ? 100 : d;
    endfunction

    task automatic check_pwm(input string req);
        hclk(5);
        measure_pwm();
        for (int f = 0; f < 3; f++) chk(req, pcnt[f], exp_pwm(f));
    endtask

    task automatic pulse(input int f, input int hi, input int lo);
        tach[f] = 1'b1; hclk(hi);
        tach[f] = 1'b0; hclk(lo);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int sum;
        int drv;
        int base;
        void'($urandom(32'd4177));
        m_en = 3'b111;
        for (int f = 0; f < 3; f++) m_duty[f] = 30;
        hclk(4);
        rst_n = 1'b1;
        hclk(4);

        // R11 / R3 / R6: reset state
        chk("R11 sda released after reset", int'(sda_oe), 0);
        check_pwm("R3 R6 reset duty 30");

        // R1 / R4 / R3: read control register at the matching address
        do_read(8'd0, 1);
        chk("R1 address ack", int'(aack), 1);
        chk("R3 R4 control reset 0x07", int'(rbuf[0]), 7);

        // R1: foreign address is not acked and its payload is ignored
        begin
            logic a;
            bus_start();
            send_byte(8'hEA, a);
            chk("R1 foreign address nack", int'(a), 0);
            send_byte(8'h00, a);
            send_byte(8'h00, a);
            bus_stop();
            chk("R11 sda released after stop", int'(sda_oe), 0);
        end
        do_read(8'd0, 1);
        chk("R1 control unchanged", int'(rbuf[0]), 7);
        check_pwm("R1 duties unchanged");

        // R2: pointer above 3 nacked
        wbuf[0] = 8'h00;
        do_write(8'd5, 1);
        chk("R2 pointer 5 nack", int'(rack), 0);
        chk("R2 pointer 5 data ignored", int'(dack[0]), 0);
        do_read(8'd0, 1);
        chk("R2 control unchanged", int'(rbuf[0]), 7);

        // R5: clamp above 100
        wbuf[0] = 8'd200;
        do_write(8'd1, 1);
        chk("R2 pointer 1 ack", int'(rack), 1);
        m_duty[0] = 100;
        check_pwm("R5 clamp to 100");

        // R9: sequential write, then pointer passes 3
        wbuf[0] = 8'd40; wbuf[1] = 8'd55; wbuf[2] = 8'd99;
        do_write(8'd2, 3);
        chk("R9 byte to reg2 ack", int'(dack[0]), 1);
        chk("R9 byte to reg3 ack", int'(dack[1]), 1);
        chk("R9 byte past reg3 nack", int'(dack[2]), 0);
        m_duty[1] = 40; m_duty[2] = 55;
        check_pwm("R9 R6 sequential duties");

        // R4 / R6: disabled fans stay low
        wbuf[0] = 8'hFA;
        do_write(8'd0, 1);
        m_en = 3'b010;
        check_pwm("R6 disabled fans low");
        do_read(8'd0, 1);
        chk("R4 mask readback upper zero", int'(rbuf[0]), 2);

        // R10: fresh START read from the current pointer
        do_write(8'd0, 0);
        begin
            logic a;
            logic [7:0] b;
            bus_start();
            send_byte(8'hE9, a);
            recv_byte(1'b0, b);
            bus_stop();
            chk("R10 read at current pointer", int'(b), 2);
        end

        // R5 R6 R4: constrained random writes
        for (int it = 0; it < 30; it++) begin
            int r;
            int d;
            r = int'($urandom_range(3, 0));
            d = int'($urandom_range(255, 0));
            if (it == 0) begin r = 2; d = 101; end
            if (it == 1) begin r = 3; d = 0; end
            if (it == 2) begin r = 1; d = 100; end
            if (it == 3) begin r = 0; d = 7; end
            wbuf[0] = 8'(d);
            do_write(8'(r), 1);
            chk("R5 random write ack", int'(dack[0]), 1);
            if (r == 0) m_en = 3'(d);
            else        m_duty[r - 1] = clamp(d);
            check_pwm("R5 R6 random duty");
            if (r == 0) begin
                do_read(8'd0, 1);
                chk("R4 random mask read", int'(rbuf[0]), d & 7);
            end
        end

        // R8 / R7 / R9: counts, saturation, sequential read
        base = ((cyc / T) + 1) * T;
        wait_until(base + 200);
        for (int i = 0; i < 300; i++) begin
            tach[2] = 1'b1;
            if (i < 37) tach[1] = 1'b1;
            hclk(5);
            tach = 3'b000;
            hclk(5);
        end
        wait_until(base + T + 100);
        do_read(8'd0, 5);
        chk("R9 R4 seq read mask", int'(rbuf[0]), int'(m_en));
        chk("R8 fan1 idle zero", int'(rbuf[1]), 0);
        chk("R7 R8 fan2 speed not duty", int'(rbuf[2]), 37);
        chk("R8 fan3 saturates", int'(rbuf[3]), 255);
        chk("R7 pointer 4 reads zero", int'(rbuf[4]), 0);

        // R8: edge versus window boundary sweep on fan 1
        base = ((cyc / T) + 1) * T;
        sum = 0;
        drv = 0;
        for (int d = -6; d <= 6; d++) begin
            int w;
            w = d + 6;
            wait_until(base + w * T + 100);
            if (w > 0) begin
                do_read(8'd1, 1);
                chk_rng("R8 window count", int'(rbuf[0]), 5, 7);
                sum += int'(rbuf[0]);
            end
            wait_until(base + w * T + 2000);
            for (int p = 0; p < 5; p++) pulse(0, 20, 20);
            drv += 5;
            wait_until(base + (w + 1) * T + d);
            pulse(0, 10, 0);
            drv += 1;
        end
        wait_until(base + 13 * T + 100);
        do_read(8'd1, 1);
        sum += int'(rbuf[0]);
        wait_until(base + 14 * T + 100);
        do_read(8'd1, 1);
        chk_rng("R8 last boundary window", int'(rbuf[0]), 0, 1);
        sum += int'(rbuf[0]);
        chk("R8 boundary pulses conserved", sum, drv);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule